// File: doc/BRIEF.md
# Converter Auto-Trigger Start Logic

This block decides when an analog-to-digital converter sequencer may begin a new conversion. It sits beside the sequencer. A 3-bit select picks one of eight hardware trigger inputs. Each input may be asynchronous, so it passes through a synchroniser before a rising-edge detector looks at it. When auto-triggering is enabled, a qualifying edge produces a one-cycle conversion start pulse. In the same cycle it produces a prescaler reset pulse, so that the converter clock phase is fixed relative to the trigger.

Edges that arrive while the converter is busy are dropped, not queued. For an ordinary source, an edge is also dropped while the completion flag is still set. One select code chains conversions instead: each falling edge of the busy status starts the next conversion, whether or not the flag has been cleared. A software start request is honoured in every mode whenever the converter is idle, so the first conversion of a chain comes from software.

Top module: `conv_trigger`

## Requirements
- R1: While reset is high and on the first cycle after it, `conv_start` and `presc_rst` are low.
- R2: With `auto_en` high, `busy` and `done_flag` low, and `trig_sel` not 0, a rising edge on `trig_src[trig_sel]` gives `conv_start` and `presc_rst` high together for exactly one cycle. This happens after the third rising clock edge following the input change (two synchroniser stages plus one output register).
- R3: With `auto_en` low, edges on any trigger source produce no output.
- R4: An edge whose decision cycle finds `busy` high is dropped. It does not start a conversion after `busy` later falls.
- R5: A trigger level that stays high produces only one start. It never starts another conversion later.
- R6: For `trig_sel` not 0, an edge that arrives while `done_flag` is high is dropped.
- R7: `trig_sel` = 0 is chained mode. With `auto_en` high, a 1-to-0 transition of `busy` gives `conv_start` and `presc_rst` one cycle later, regardless of `done_flag`. In this mode `trig_src[0]` has no effect.
- R8: A one-cycle `sw_start` while `busy` is low gives `conv_start` the next cycle, without `presc_rst`, whatever the value of `auto_en`. A `sw_start` while `busy` is high is ignored.
- R9: Switching `trig_sel` to a source that is already held high produces no start.
- R10: A software request and a hardware trigger in the same decision cycle give a single one-cycle start with `presc_rst` high.
- R11: `conv_start` is never high on two consecutive cycles, and `presc_rst` is only high together with `conv_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_src | input | 8 | Hardware trigger sources, may be asynchronous |
| trig_sel | input | 3 | Source select; 0 selects chained mode |
| auto_en | input | 1 | Auto-trigger enable |
| busy | input | 1 | Conversion in progress, from the sequencer |
| done_flag | input | 1 | Completion flag, set by the sequencer and cleared by software |
| sw_start | input | 1 | One-cycle software start request |
| conv_start | output | 1 | One-cycle conversion start pulse |
| presc_rst | output | 1 | One-cycle prescaler reset pulse, issued only for hardware triggers |

## Verification
A software start request and a synchronised hardware edge can reach the decision stage in the same cycle. The bench provokes this by raising `sw_start` in the cycle just before the third clock edge after the trigger input rises. The expected result is one start pulse, with the prescaler reset present, followed by a low cycle. The other contested cycle is a trigger edge meeting `busy`. The bench holds `busy` across the decision cycle and then watches well beyond its release, to confirm the edge was dropped rather than delayed.

// File: rtl/conv_trigger_pkg.sv
package conv_trigger_pkg;

    localparam int SEL_W_DEF      = 3;
    localparam int SYNC_DEF       = 2;
    localparam int CHAIN_CODE_DEF = 0;

    // Requests reaching the decision stage in one cycle
    typedef struct packed {
        logic hw;
        logic sw;
    } start_req_t;

    // Hardware trigger qualification before the busy gate
    function automatic logic hw_qualify(
        input logic en,
        input logic chained,
        input logic edge_hit,
        input logic flag,
        input logic busy_fell
    );
        if (!en)
            return 1'b0;
        if (chained)
            return busy_fell;
        return edge_hit && !flag;
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--)
                stg[i] <= stg[i-1];
            stg[0] <= din;
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
    parameter int SEL_W = 3,
    localparam int N    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     lvl,
    input  logic [SEL_W-1:0] sel,
    output logic             edge_hit
);
    logic [N-1:0] rise;

    // One history bit per source, so a select change never sees a stale level
    for (genvar g = 0; g < N; g++) begin : g_src
        logic prev;
        always_ff @(posedge clk) begin
            if (rst) prev <= 1'b0;
            else     prev <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev;
    end

    assign edge_hit = rise[sel];
endmodule

// File: rtl/start_ctl.sv
module start_ctl
    import conv_trigger_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int CHAIN_CODE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             auto_en,
    input  logic             busy,
    input  logic             done_flag,
    input  logic             sw_start,
    input  logic             edge_hit,
    output logic             conv_start,
    output logic             presc_rst
);
    logic       busy_q;
    logic       chained;
    logic       gate_open;
    start_req_t req;

    assign chained   = (sel == SEL_W'(CHAIN_CODE));
    assign gate_open = !busy && !conv_start;
    assign req.hw    = gate_open &&
                       hw_qualify(auto_en, chained, edge_hit, done_flag, busy_q && !busy);
    assign req.sw    = gate_open && sw_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            conv_start <= 1'b0;
            presc_rst  <= 1'b0;
        end else begin
            busy_q     <= busy;
            conv_start <= req.hw || req.sw;
            presc_rst  <= req.hw;
        end
    end
endmodule

// File: rtl/conv_trigger.sv
module conv_trigger
    import conv_trigger_pkg::*;
#(
    parameter int SEL_W      = SEL_W_DEF,
    parameter int SYNC       = SYNC_DEF,
    parameter int CHAIN_CODE = CHAIN_CODE_DEF,
    localparam int NSRC      = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  trig_src,
    input  logic [SEL_W-1:0] trig_sel,
    input  logic             auto_en,
    input  logic             busy,
    input  logic             done_flag,
    input  logic             sw_start,
    output logic             conv_start,
    output logic             presc_rst
);
    logic [NSRC-1:0] src_sync;
    logic            edge_hit;

    trig_sync #(.W(NSRC), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (trig_src),
        .dout(src_sync)
    );

    trig_edge #(.SEL_W(SEL_W)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl     (src_sync),
        .sel     (trig_sel),
        .edge_hit(edge_hit)
    );

    start_ctl #(.SEL_W(SEL_W), .CHAIN_CODE(CHAIN_CODE)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .sel       (trig_sel),
        .auto_en   (auto_en),
        .busy      (busy),
        .done_flag (done_flag),
        .sw_start  (sw_start),
        .edge_hit  (edge_hit),
        .conv_start(conv_start),
        .presc_rst (presc_rst)
    );
endmodule

// File: rtl/conv_trigger_chk.sv
module conv_trigger_chk #(
    parameter int SEL_W      = 3,
    parameter int CHAIN_CODE = 0
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] trig_sel,
    input logic             auto_en,
    input logic             busy,
    input logic             done_flag,
    input logic             sw_start,
    input logic             conv_start,
    input logic             presc_rst
);
    p_presc_with_start_r11: assert property (@(posedge clk) disable iff (rst)
        presc_rst |-> conv_start);

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    p_busy_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !conv_start);

    p_auto_gate_r3: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> !presc_rst);

    p_sw_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_start && !busy && !conv_start) |=> conv_start);

    p_flag_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (done_flag && trig_sel != SEL_W'(CHAIN_CODE)) |=> !presc_rst);
endmodule

bind conv_trigger conv_trigger_chk #(.SEL_W(SEL_W), .CHAIN_CODE(CHAIN_CODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .trig_sel  (trig_sel),
    .auto_en   (auto_en),
    .busy      (busy),
    .done_flag (done_flag),
    .sw_start  (sw_start),
    .conv_start(conv_start),
    .presc_rst (presc_rst)
);

// File: tb/conv_trigger_tb.sv
module conv_trigger_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] trig_src = '0;
    logic [2:0] trig_sel = '0;
    logic       auto_en = 1'b0;
    logic       busy = 1'b0;
    logic       done_flag = 1'b0;
    logic       sw_start = 1'b0;
    logic       conv_start;
    logic       presc_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    conv_trigger u_dut (
        .clk(clk), .rst(rst), .trig_src(trig_src), .trig_sel(trig_sel),
        .auto_en(auto_en), .busy(busy), .done_flag(done_flag),
        .sw_start(sw_start), .conv_start(conv_start), .presc_rst(presc_rst)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic count_starts(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (conv_start) c++;
        end
    endtask

    task automatic settle();
        trig_src = '0; sw_start = 0; busy = 0; done_flag = 0;
        repeat (4) tick();
    endtask

    // Expected hardware start for an ordinary source edge
    function automatic logic exp_hw(input logic en, input logic flag, input logic bsy);
        return en && !flag && !bsy;
    endfunction

    int c;
    logic e;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        @(negedge clk);
        check("R1 start in reset", conv_start, 1'b0);
        check("R1 presc in reset", presc_rst, 1'b0);
        tick(); rst = 0;
        tick();
        check("R1 start after reset", conv_start, 1'b0);
        check("R1 presc after reset", presc_rst, 1'b0);

        // R2 and R5: edge latency, single pulse, held level
        trig_sel = 3; auto_en = 1; settle();
        trig_src[3] = 1;
        tick(); tick();
        check("R2 no start before third edge", conv_start, 1'b0);
        tick();
        check("R2 start on third edge", conv_start, 1'b1);
        check("R2 presc on third edge", presc_rst, 1'b1);
        tick();
        check("R2 pulse one cycle", conv_start, 1'b0);
        count_starts(12, c);
        check("R5 held level no restart", c == 0, 1'b1);

        // R3: disabled
        auto_en = 0; trig_sel = 2; settle();
        trig_src[2] = 1;
        count_starts(8, c);
        check("R3 auto disabled", c == 0, 1'b1);

        // R6: flag set blocks ordinary source
        auto_en = 1; trig_sel = 5; settle();
        done_flag = 1; trig_src[5] = 1;
        count_starts(8, c);
        check("R6 flag blocks edge", c == 0, 1'b1);

        // R4: busy drops the edge
        trig_sel = 4; settle();
        busy = 1; trig_src[4] = 1;
        repeat (5) tick();
        busy = 0;
        count_starts(8, c);
        check("R4 edge during busy dropped", c == 0, 1'b1);

        // R9: select change onto a high source
        trig_sel = 1; settle();
        trig_src[6] = 1;
        repeat (5) tick();
        trig_sel = 6;
        count_starts(8, c);
        check("R9 select change no start", c == 0, 1'b1);

        // R8: software start
        auto_en = 0; settle();
        sw_start = 1; tick(); sw_start = 0;
        check("R8 sw start accepted", conv_start, 1'b1);
        check("R8 sw start no presc", presc_rst, 1'b0);
        busy = 1; sw_start = 1; tick(); sw_start = 0;
        check("R8 sw start during busy ignored", conv_start, 1'b0);
        count_starts(3, c);
        check("R8 no late sw start", c == 0, 1'b1);

        // R7: chained mode
        auto_en = 1; trig_sel = 0; settle();
        trig_src[0] = 1;
        count_starts(8, c);
        check("R7 src0 ignored in chained mode", c == 0, 1'b1);
        busy = 1; done_flag = 1;
        repeat (3) tick();
        busy = 0; tick();
        check("R7 chained start on busy fall", conv_start, 1'b1);
        check("R7 chained presc on busy fall", presc_rst, 1'b1);
        tick();
        check("R7 chained pulse one cycle", conv_start, 1'b0);

        // R10: software and hardware in the same decision cycle
        trig_sel = 7; settle();
        trig_src[7] = 1;
        tick(); tick();
        sw_start = 1; tick(); sw_start = 0;
        check("R10 coincident start", conv_start, 1'b1);
        check("R10 coincident presc", presc_rst, 1'b1);
        tick();
        check("R10 single pulse", conv_start, 1'b0);

        // Random ordinary-source edges (R2, R3, R6)
        for (int k = 0; k < 40; k++) begin
            trig_sel  = 3'(1 + ($urandom % 7));
            auto_en   = 1'($urandom % 2);
            settle();
            done_flag = 1'($urandom % 2);
            trig_src  = 8'($urandom) | (8'd1 << trig_sel);
            tick(); tick(); tick();
            e = exp_hw(auto_en, done_flag, 1'b0);
            check("R2 random start", conv_start, e);
            check("R6 random presc", presc_rst, e);
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule